// File: doc/BRIEF.md
# Memory Hex Dump Streamer

The block turns a single start request into a readable text dump of a byte window of memory. A start pulse carries a centre address. The block derives a window around that centre and reads the window one byte at a time through a simple request/response memory port. It writes the result as a stream of 8-bit ASCII characters on a valid/ready output.

The text is organised in lines of sixteen bytes. Each line starts with the address of its first byte. The byte values follow in hexadecimal. A full line then closes with a column that shows each byte as a character where that can be displayed. A one-cycle done flag marks the end of the dump. A typical consumer is a debug console or a trace channel that forwards the characters unchanged.

Top module: `hexdump_streamer`

## Requirements
- R1: When the centre address is below 0x80, the window starts at address 0 and holds centre + 0x80 bytes.
- R2: When the centre address is 0x80 or more, the window starts at centre - 0x80 and holds 0x100 bytes. Addresses wrap modulo 2^32.
- R3: Each line begins with the address of its first byte. The address is written as 8 lowercase, zero-padded hex digits (0x30-0x39, 0x61-0x66), followed by ':' (0x3A) and a space (0x20).
- R4: Each byte of the window is read once, in ascending address order, from mem_addr_o. It is written as two lowercase hex digits, high nibble first, followed by a space.
- R5: After the sixteenth byte of a line, the block emits '|' (0x7C), a space, sixteen view characters and a newline (0x0A).
- R6: In the view column, a byte from 0x20 to 0x7E inclusive appears as itself. Any other byte appears as '.' (0x2E). Every line starts with a view column that is all '.'.
- R7: If the window size is not a multiple of 16, the last line ends with the space after its final byte. That line has no '|', no view column and no newline.
- R8: While char_valid_o is high and char_ready_i is low, char_valid_o stays high and char_data_o holds its value. No character is lost or repeated.
- R9: mem_req_o is high for a single cycle. No new request is made until mem_rsp_valid_i has returned the previous byte.
- R10: done_o is high for exactly one cycle, the cycle after the final character is accepted. busy_o stays high from the accepted start until that cycle.
- R11: A start pulse while busy_o is high is ignored. The dump in progress is unchanged, and no second dump follows it.
- R12: Out of reset, busy_o, char_valid_o, mem_req_o and done_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, taken only while idle |
| centre_i | input | 32 | Centre address of the requested window |
| busy_o | output | 1 | A dump is in progress |
| mem_req_o | output | 1 | One-cycle byte read request |
| mem_addr_o | output | 32 | Byte address of the read |
| mem_rsp_valid_i | input | 1 | Read data is valid this cycle |
| mem_rsp_data_i | input | 8 | Read data byte |
| char_valid_o | output | 1 | Output character is valid |
| char_data_o | output | 8 | ASCII character |
| char_ready_i | input | 1 | Consumer accepts the character |
| done_o | output | 1 | One-cycle pulse after the last character |

## Verification
The assertions assume that the memory returns exactly one response for each request, at least one cycle after it, and never a response when nothing is pending. The bench memory model meets this by holding one pending request and answering it after a set latency of one to three cycles. The bench also flags any request that arrives while a response is still pending. The assertions further assume that char_ready_i may change freely, but only between clock edges. The bench changes it at the falling edge, from a fixed-high setting or from pseudo-random patterns that are mostly high or mostly low.

// File: rtl/hexdump_pkg.sv
package hexdump_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_COLON, S_ASP, S_REQ, S_WAIT, S_HI, S_LO,
    S_BSP, S_BAR, S_BARSP, S_TXT, S_NL, S_DONE
  } dump_state_e;

  localparam logic [7:0] CH_SPACE = 8'h20;
  localparam logic [7:0] CH_COLON = 8'h3a;
  localparam logic [7:0] CH_BAR   = 8'h7c;
  localparam logic [7:0] CH_NL    = 8'h0a;
  localparam logic [7:0] CH_DOT   = 8'h2e;

  function automatic logic [7:0] hex_char(input logic [3:0] n);
    return (n < 4'd10) ? (8'h30 + {4'h0, n}) : (8'h57 + {4'h0, n});
  endfunction

  function automatic logic [7:0] view_char(input logic [7:0] b);
    return (b >= 8'h20 && b <= 8'h7e) ? b : CH_DOT;
  endfunction

endpackage

// File: rtl/hexdump_window.sv
module hexdump_window #(
  parameter int ADDR_W   = 32,
  parameter int HALF_WIN = 128,
  parameter int CNT_W    = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] centre_i,
  output logic [ADDR_W-1:0] base_o,
  output logic [CNT_W-1:0]  size_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_o <= '0;
      size_o <= '0;
    end else if (load_i) begin
      if (centre_i < ADDR_W'(HALF_WIN)) begin
        base_o <= '0;
        size_o <= CNT_W'(centre_i) + CNT_W'(HALF_WIN);
      end else begin
        base_o <= centre_i - ADDR_W'(HALF_WIN);
        size_o <= CNT_W'(2 * HALF_WIN);
      end
    end
  end

endmodule

// File: rtl/hexdump_linebuf.sv
module hexdump_linebuf
  import hexdump_pkg::*;
#(
  parameter int LINE_BYTES = 16,
  parameter int IDX_W      = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [7:0]       wr_byte_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [7:0]       rd_char_o
);

  logic [7:0] cell_q [LINE_BYTES];

  for (genvar i = 0; i < LINE_BYTES; i++) begin : g_cell
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                       cell_q[i] <= CH_DOT;
      else if (clear_i)                                  cell_q[i] <= CH_DOT;
      else if (wr_en_i && (wr_idx_i == IDX_W'(i)))       cell_q[i] <= view_char(wr_byte_i);
    end
  end

  assign rd_char_o = cell_q[rd_idx_i];

endmodule

// File: rtl/hexdump_streamer.sv
module hexdump_streamer
  import hexdump_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 16,
  parameter int HALF_WIN   = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] centre_i,
  output logic              busy_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_rsp_valid_i,
  input  logic [7:0]        mem_rsp_data_i,
  output logic              char_valid_o,
  output logic [7:0]        char_data_o,
  input  logic              char_ready_i,
  output logic              done_o
);

  localparam int HEX_DIGITS = ADDR_W / 4;
  localparam int POS_W      = $clog2(LINE_BYTES);
  localparam int CNT_W      = $clog2(2 * HALF_WIN + 1);
  localparam int DIG_MAX    = (HEX_DIGITS > LINE_BYTES) ? HEX_DIGITS : LINE_BYTES;
  localparam int DIG_W      = $clog2(DIG_MAX);

  dump_state_e       state_q, state_d;
  logic [CNT_W-1:0]  off_q, off_d;
  logic [DIG_W-1:0]  dig_q, dig_d;
  logic [7:0]        byte_q, byte_d;
  logic [ADDR_W-1:0] base;
  logic [CNT_W-1:0]  size;
  logic [ADDR_W-1:0] cur_addr;
  logic [3:0]        addr_nib;
  logic [7:0]        view_rd;
  logic [POS_W-1:0]  pos;
  logic              line_end, last_byte, fire, load, buf_clear, buf_wr;

  assign load      = (state_q == S_IDLE) && start_i;
  assign pos       = off_q[POS_W-1:0];
  assign line_end  = (pos == POS_W'(LINE_BYTES - 1));
  assign last_byte = ((off_q + CNT_W'(1)) == size);
  assign cur_addr  = base + ADDR_W'(off_q);
  assign fire      = char_valid_o && char_ready_i;
  assign buf_clear = load || ((state_q == S_NL) && fire && !last_byte);
  assign buf_wr    = (state_q == S_WAIT) && mem_rsp_valid_i;

  hexdump_window #(
    .ADDR_W  (ADDR_W),
    .HALF_WIN(HALF_WIN),
    .CNT_W   (CNT_W)
  ) u_window (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .centre_i(centre_i),
    .base_o  (base),
    .size_o  (size)
  );

  hexdump_linebuf #(
    .LINE_BYTES(LINE_BYTES),
    .IDX_W     (POS_W)
  ) u_linebuf (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (buf_clear),
    .wr_en_i  (buf_wr),
    .wr_idx_i (pos),
    .wr_byte_i(mem_rsp_data_i),
    .rd_idx_i (dig_q[POS_W-1:0]),
    .rd_char_o(view_rd)
  );

  // most significant digit first
  always_comb addr_nib = 4'(cur_addr >> (4 * (HEX_DIGITS - 1 - int'(dig_q))));

  always_comb begin
    state_d = state_q;
    off_d   = off_q;
    dig_d   = dig_q;
    byte_d  = byte_q;
    unique case (state_q)
      S_IDLE: if (start_i) begin
        state_d = S_ADDR;
        off_d   = '0;
        dig_d   = '0;
      end
      S_ADDR: if (char_ready_i) begin
        if (dig_q == DIG_W'(HEX_DIGITS - 1)) begin
          dig_d   = '0;
          state_d = S_COLON;
        end else begin
          dig_d = dig_q + DIG_W'(1);
        end
      end
      S_COLON: if (char_ready_i) state_d = S_ASP;
      S_ASP:   if (char_ready_i) state_d = S_REQ;
      S_REQ:   state_d = S_WAIT;
      S_WAIT: if (mem_rsp_valid_i) begin
        byte_d  = mem_rsp_data_i;
        state_d = S_HI;
      end
      S_HI: if (char_ready_i) state_d = S_LO;
      S_LO: if (char_ready_i) state_d = S_BSP;
      S_BSP: if (char_ready_i) begin
        if (line_end)       state_d = S_BAR;
        else if (last_byte) state_d = S_DONE;
        else begin
          off_d   = off_q + CNT_W'(1);
          state_d = S_REQ;
        end
      end
      S_BAR:   if (char_ready_i) state_d = S_BARSP;
      S_BARSP: if (char_ready_i) state_d = S_TXT;
      S_TXT: if (char_ready_i) begin
        if (dig_q == DIG_W'(LINE_BYTES - 1)) begin
          dig_d   = '0;
          state_d = S_NL;
        end else begin
          dig_d = dig_q + DIG_W'(1);
        end
      end
      S_NL: if (char_ready_i) begin
        if (last_byte) state_d = S_DONE;
        else begin
          off_d   = off_q + CNT_W'(1);
          state_d = S_ADDR;
        end
      end
      S_DONE:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      off_q   <= '0;
      dig_q   <= '0;
      byte_q  <= '0;
    end else begin
      state_q <= state_d;
      off_q   <= off_d;
      dig_q   <= dig_d;
      byte_q  <= byte_d;
    end
  end

  always_comb begin
    char_valid_o = 1'b1;
    char_data_o  = CH_SPACE;
    unique case (state_q)
      S_ADDR:                  char_data_o = hex_char(addr_nib);
      S_COLON:                 char_data_o = CH_COLON;
      S_ASP, S_BSP, S_BARSP:   char_data_o = CH_SPACE;
      S_HI:                    char_data_o = hex_char(byte_q[7:4]);
      S_LO:                    char_data_o = hex_char(byte_q[3:0]);
      S_BAR:                   char_data_o = CH_BAR;
      S_TXT:                   char_data_o = view_rd;
      S_NL:                    char_data_o = CH_NL;
      default:                 char_valid_o = 1'b0;
    endcase
  end

  assign busy_o     = (state_q != S_IDLE);
  assign done_o     = (state_q == S_DONE);
  assign mem_req_o  = (state_q == S_REQ);
  assign mem_addr_o = cur_addr;

endmodule

// File: rtl/hexdump_streamer_chk.sv
module hexdump_streamer_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       busy_o,
  input logic       mem_req_o,
  input logic       mem_rsp_valid_i,
  input logic       char_valid_o,
  input logic [7:0] char_data_o,
  input logic       char_ready_i,
  input logic       done_o
);

  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              pend_q <= 1'b0;
    else if (mem_req_o)       pend_q <= 1'b1;
    else if (mem_rsp_valid_i) pend_q <= 1'b0;
  end

  AST_ONE_OUTSTANDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !pend_q); // R9
  AST_REQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o); // R9
  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (char_valid_o && !char_ready_i) |=> (char_valid_o && $stable(char_data_o))); // R8
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R10
  AST_DONE_AFTER_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(char_valid_o && char_ready_i)); // R10
  AST_QUIET_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!char_valid_o && !mem_req_o && !done_o)); // R12
  AST_CHAR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    char_valid_o |-> ((char_data_o >= 8'h20 && char_data_o <= 8'h7e) || char_data_o == 8'h0a)); // R6
  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o && start_i) |=> busy_o); // R11

endmodule

bind hexdump_streamer hexdump_streamer_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .start_i        (start_i),
  .busy_o         (busy_o),
  .mem_req_o      (mem_req_o),
  .mem_rsp_valid_i(mem_rsp_valid_i),
  .char_valid_o   (char_valid_o),
  .char_data_o    (char_data_o),
  .char_ready_i   (char_ready_i),
  .done_o         (done_o)
);

// File: tb/hexdump_streamer_bench.sv
module hexdump_streamer_bench;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] centre_i = '0;
  logic        busy_o, mem_req_o, char_valid_o, done_o;
  logic [31:0] mem_addr_o;
  logic        mem_rsp_valid_i = 1'b0;
  logic [7:0]  mem_rsp_data_i = '0;
  logic [7:0]  char_data_o;
  logic        char_ready_i = 1'b0;

  int n_checks = 0;
  int n_fails  = 0;

  always #4 clk_i = ~clk_i;

  hexdump_streamer u_hexdump_streamer (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .centre_i(centre_i),
    .busy_o(busy_o), .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
    .mem_rsp_valid_i(mem_rsp_valid_i), .mem_rsp_data_i(mem_rsp_data_i),
    .char_valid_o(char_valid_o), .char_data_o(char_data_o),
    .char_ready_i(char_ready_i), .done_o(done_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] mdat(input logic [31:0] a);
    return (a[7:0] * 8'd5) ^ a[15:8] ^ 8'h1f;
  endfunction

  // expected stream state
  byte unsigned exp_q[$];
  string        exp_tag[$];
  byte unsigned got_q[$];
  logic [31:0]  exp_base;
  int           exp_size;
  int           rd_cnt;
  int           done_cnt;
  int           ready_mode;
  int           mem_lat;

  // monitor / memory model / ready driver, all at the falling edge
  logic [15:0] lfsr = 16'hace1;
  bit          prev_stall, prev_hs, prev_done;
  logic [7:0]  prev_char;
  int          pend;
  logic [31:0] pend_addr;

  always @(negedge clk_i) begin
    bit rdy, hs;
    if (rst_ni) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (ready_mode)
        0:       rdy = 1'b1;
        1:       rdy = lfsr[0] | lfsr[3];
        default: rdy = (lfsr[2:0] == 3'd0);
      endcase
      char_ready_i = rdy;
      if (prev_stall)
        check(char_valid_o && char_data_o == prev_char, "R8", "stalled char changed",
              {55'd0, char_valid_o, char_data_o}, {56'd1, prev_char});
      prev_stall = char_valid_o && !rdy;
      prev_char  = char_data_o;
      hs = char_valid_o && rdy;
      if (hs) got_q.push_back(char_data_o);
      if (prev_done) check(!done_o, "R10", "done wider than one cycle", 64'(done_o), 0);
      if (done_o) begin
        done_cnt++;
        check(prev_hs && got_q.size() == exp_q.size(), "R10", "done timing/char count",
              64'(got_q.size()), 64'(exp_q.size()));
      end
      prev_hs   = hs;
      prev_done = done_o;
      // memory response
      mem_rsp_valid_i = 1'b0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          mem_rsp_valid_i = 1'b1;
          mem_rsp_data_i  = mdat(pend_addr);
        end
      end
      if (mem_req_o) begin
        check(pend == 0 && !mem_rsp_valid_i, "R9", "request while one pending", 64'(pend), 0);
        check(mem_addr_o == exp_base + 32'(rd_cnt), "R4", "read address order",
              64'(mem_addr_o), 64'(exp_base + 32'(rd_cnt)));
        rd_cnt++;
        pend      = mem_lat;
        pend_addr = mem_addr_o;
      end
    end
  end

  task automatic build_expected(input logic [31:0] c);
    string hx = "0123456789abcdef";
    byte unsigned vbuf[16];
    exp_q.delete();
    exp_tag.delete();
    if (c < 32'h80) begin exp_base = 32'h0; exp_size = int'(c) + 128; end
    else begin exp_base = c - 32'h80; exp_size = 256; end
    for (int s = 0; s < exp_size; s++) begin
      logic [31:0] a = exp_base + 32'(s);
      logic [7:0]  b = mdat(a);
      if (s % 16 == 0) begin
        for (int d = 7; d >= 0; d--) begin
          exp_q.push_back(hx[(a >> (4 * d)) & 32'hf]); exp_tag.push_back("R3");
        end
        exp_q.push_back(8'h3a); exp_tag.push_back("R3");
        exp_q.push_back(8'h20); exp_tag.push_back("R3");
        foreach (vbuf[k]) vbuf[k] = 8'h2e;
      end
      exp_q.push_back(hx[b[7:4]]); exp_tag.push_back("R4");
      exp_q.push_back(hx[b[3:0]]); exp_tag.push_back("R4");
      exp_q.push_back(8'h20);      exp_tag.push_back("R4");
      if (b >= 8'h20 && b <= 8'h7e) vbuf[s % 16] = b;
      if (s % 16 == 15) begin
        exp_q.push_back(8'h7c); exp_tag.push_back("R5");
        exp_q.push_back(8'h20); exp_tag.push_back("R5");
        for (int k = 0; k < 16; k++) begin
          exp_q.push_back(vbuf[k]); exp_tag.push_back("R6");
        end
        exp_q.push_back(8'h0a); exp_tag.push_back("R5");
      end
    end
  endtask

  task automatic run_dump(input logic [31:0] c, input int rmode, input int lat, input bit poke);
    string win_tag = (c < 32'h80) ? "R1" : "R2";
    bit    same;
    int    bad;
    build_expected(c);
    ready_mode = rmode;
    mem_lat    = lat;
    got_q.delete();
    rd_cnt   = 0;
    done_cnt = 0;
    @(negedge clk_i);
    start_i  = 1'b1;
    centre_i = c;
    @(negedge clk_i);
    start_i  = 1'b0;
    for (int n = 0; n < 40000 && done_cnt == 0; n++) begin
      @(negedge clk_i);
      if (poke && n == 300) begin start_i = 1'b1; centre_i = 32'h0; end
      else start_i = 1'b0;
    end
    start_i = 1'b0;
    check(done_cnt == 1, "R10", "dump did not finish", 64'(done_cnt), 1);
    repeat (4) @(negedge clk_i);
    check(!busy_o && done_cnt == 1, "R11", "block active after dump", 64'(busy_o), 0);
    check(rd_cnt == exp_size, win_tag, "window byte count", 64'(rd_cnt), 64'(exp_size));
    check(got_q.size() == exp_q.size(), win_tag, "stream length",
          64'(got_q.size()), 64'(exp_q.size()));
    same = 1'b1;
    bad  = -1;
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
      if (got_q[i] != exp_q[i] && bad < 0) begin same = 1'b0; bad = i; end
    if (bad >= 0)
      check(1'b0, exp_tag[bad], $sformatf("stream char %0d", bad), 64'(got_q[bad]), 64'(exp_q[bad]));
    else
      check(1'b1, "R4", "stream content", 0, 0);
    if (exp_size % 16 != 0)
      check(got_q.size() > 0 && got_q[got_q.size()-1] == 8'h20 && same, "R7",
            "partial line tail", (got_q.size() > 0) ? 64'(got_q[got_q.size()-1]) : 64'hff, 64'h20);
    if (poke)
      check(same && got_q.size() == exp_q.size(), "R11", "start while busy altered dump",
            64'(got_q.size()), 64'(exp_q.size()));
  endtask

  task automatic t_reset;
    check(!busy_o && !char_valid_o && !mem_req_o && !done_o, "R12", "reset outputs",
          {60'd0, busy_o, char_valid_o, mem_req_o, done_o}, 0);
  endtask

  task automatic t_high_window;   run_dump(32'h0000_1000, 0, 1, 1'b0); endtask // R2
  task automatic t_low_partial;   run_dump(32'h0000_0005, 1, 3, 1'b0); endtask // R1, R7
  task automatic t_below_edge;    run_dump(32'h0000_007f, 2, 2, 1'b0); endtask // R1, R8
  task automatic t_at_edge;       run_dump(32'h0000_0080, 1, 1, 1'b0); endtask // R2
  task automatic t_wrap_top;      run_dump(32'hffff_fff0, 0, 2, 1'b0); endtask // R2, R3
  task automatic t_busy_start;    run_dump(32'h0000_2345, 1, 1, 1'b1); endtask // R11

  initial begin
    repeat (200000) @(posedge clk_i);
    check(1'b0, "R10", "watchdog expired", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_high_window();
    t_low_partial();
    t_below_edge();
    t_at_edge();
    t_wrap_top();
    t_busy_start();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

endmodule